// File: doc/BRIEF.md
# Cartridge Protection ALU with OR-Combined Banking

This block sits between a 24-bit CPU bus and a cartridge ROM. It provides a small copy-protection device and a bank register for the low part of the address space.

A write into the lower protection window stores one of two values, chosen by CPU address bit 1. It stores either a full byte of operand or a 2-bit operation code. Any read address inside the protection area raises a hit flag. While the hit flag is high, the result byte carries the stored operand after the selected bit operation.

A write into the upper protection window sets a bank base. The base is the written byte placed at 32 KB granularity. The write is refused when a 64 KB window starting at that base would reach past the end of the ROM.

CPU read addresses inside the first megabyte are combined with the bank base by bitwise OR, not by addition. This produces the ROM address. Addresses above the first megabyte pass through unchanged.

Top module: `prot_or_bank_alu`

## Requirements
- R1: Reset (synchronous, active high) clears the operand, the operation code and the bank base to zero. Afterwards the result is 0x00 and the ROM address equals the CPU read address.
- R2: A write whose address lies in 0x600000–0x6FFFFF with address bit 1 equal to 0 loads all 8 bits of the write data into the operand register, from the next clock edge.
- R3: A write in 0x600000–0x6FFFFF with address bit 1 equal to 1 loads write-data bits 1:0 into the operation code and leaves the operand unchanged.
- R4: Operation code 0 yields the operand shifted left by one bit and truncated to 8 bits (0xA5 gives 0x4A).
- R5: Operation code 1 yields the operand shifted right by one bit with a zero fill (0xA5 gives 0x52).
- R6: Operation code 2 yields the operand with its high and low nibbles exchanged (0xA5 gives 0x5A).
- R7: Operation code 3 yields the operand with its bit order reversed, so bit 0 goes to bit 7 (0x1E gives 0x78).
- R8: The hit output is 1 exactly when the read address lies in 0x600000–0x7FFFFF.
- R9: A write in 0x700000–0x7FFFFF sets the bank base to the write byte shifted left by 15, provided the range check of R10 passes.
- R10: A bank write is rejected, and the old base kept, when (byte << 15) + 0x10000 is at or above the ROM size. With the default ROM size of 0x400000, byte 125 is accepted and byte 126 is rejected.
- R11: For a read address below 0x100000, the ROM address is the read address ORed with the bank base. For any other read address, the ROM address equals the read address.
- R12: Writes outside 0x600000–0x7FFFFF change neither the operand, the operation code nor the bank base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 24 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 24 | CPU read address |
| prot_hit | output | 1 | Read address lies in the protection area |
| prot_data | output | 8 | Result of the selected operation on the operand |
| rom_addr | output | 24 | Translated ROM address |

## Verification
The hardest behaviour to reach from the ports is the range check exactly at its edge. It only shows up when a refused write is followed by a read whose translated address still carries the previous base. The stimulus first loads base byte 125, the largest one that fits, then writes byte 126 and byte 255. It reads address 0 after each write, so a refusal shows up as an unchanged ROM address.

The OR combination is set apart from addition in a separate step. A read address is chosen whose bit 15 overlaps a set base bit, so the two combinations give different ROM addresses.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_SHL  = 2'd0,
        OP_SHR  = 2'd1,
        OP_SWAP = 2'd2,
        OP_REV  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_OPND,
        TGT_OPCODE,
        TGT_BANK
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [BYTE_W-1:0] val;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] apply_op(op_e op, logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        case (op)
            OP_SHL:  r = {d[BYTE_W-2:0], 1'b0};
            OP_SHR:  r = {1'b0, d[BYTE_W-1:1]};
            OP_SWAP: r = {d[BYTE_W/2-1:0], d[BYTE_W-1:BYTE_W/2]};
            default: begin
                for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prot_wr_decode.sv
module prot_wr_decode
    import prot_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int REGION_LSB  = 20,
    parameter int OPND_REGION = 6,
    parameter int BANK_REGION = 7
) (
    input  logic                    wr_en,
    input  logic [ADDR_W-REGION_LSB-1:0] region,
    input  logic                    sel_bit,
    input  logic [BYTE_W-1:0]       wr_data,
    output wr_req_t                 req
);
    localparam int RW = ADDR_W - REGION_LSB;
    localparam logic [RW-1:0] OPND_R = RW'(OPND_REGION);
    localparam logic [RW-1:0] BANK_R = RW'(BANK_REGION);

    always_comb begin
        req.val = wr_data;
        req.tgt = TGT_NONE;
        if (wr_en) begin
            if (region == OPND_R)      req.tgt = sel_bit ? TGT_OPCODE : TGT_OPND;
            else if (region == BANK_R) req.tgt = TGT_BANK;
        end
    end
endmodule

// File: rtl/prot_bank.sv
module prot_bank
    import prot_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int BANK_SHIFT = 15,
    parameter int WIN_BYTES  = 32'h10000,
    parameter int ROM_BYTES  = 32'h400000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W:0] WIN_L = (ADDR_W+1)'(WIN_BYTES);
    localparam logic [ADDR_W:0] LIM_L = (ADDR_W+1)'(ROM_BYTES);

    logic [ADDR_W-1:0] cand;
    logic [ADDR_W:0]   reach;
    logic              fits;

    assign cand  = ADDR_W'(byte_in) << BANK_SHIFT;
    assign reach = {1'b0, cand} + WIN_L;
    assign fits  = reach < LIM_L;

    always_ff @(posedge clk) begin
        if (rst)              base <= '0;
        else if (load && fits) base <= cand;
    end

    assert_bank_load_R9: assert property (@(posedge clk) disable iff (rst)
        (load && fits) |=> (base == ($past(ADDR_W'(byte_in)) << BANK_SHIFT)));

    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (load && (({1'b0, ADDR_W'(byte_in) << BANK_SHIFT} + WIN_L) >= LIM_L)) |=> $stable(base));

    assert_bank_align_R9: assert property (@(posedge clk) disable iff (rst)
        base[BANK_SHIFT-1:0] == '0);
endmodule

// File: rtl/prot_xlate.sv
module prot_xlate #(
    parameter int ADDR_W  = 24,
    parameter int LOW_LSB = 20
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] rom_addr
);
    logic low;
    assign low      = rd_addr[ADDR_W-1:LOW_LSB] == '0;
    assign rom_addr = low ? (rd_addr | base) : rd_addr;
endmodule

// File: rtl/prot_or_bank_alu.sv
module prot_or_bank_alu
    import prot_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int REGION_LSB = 20,
    parameter int BANK_SHIFT = 15,
    parameter int WIN_BYTES  = 32'h10000,
    parameter int ROM_BYTES  = 32'h400000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [23:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [23:0]       rd_addr,
    output logic              prot_hit,
    output logic [7:0]        prot_data,
    output logic [23:0]       rom_addr
);
    localparam int HIT_LSB = REGION_LSB + 1;
    localparam logic [ADDR_W-HIT_LSB-1:0] HIT_R = (ADDR_W-HIT_LSB)'(3);

    wr_req_t           req;
    logic [BYTE_W-1:0] opnd_q;
    op_e               op_q;
    logic [ADDR_W-1:0] base_q;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{wr_addr[REGION_LSB-1:2], wr_addr[0]};

    prot_wr_decode #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) i_dec (
        .wr_en   (wr_en),
        .region  (wr_addr[ADDR_W-1:REGION_LSB]),
        .sel_bit (wr_addr[1]),
        .wr_data (wr_data),
        .req     (req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
            op_q   <= OP_SHL;
        end else begin
            if (req.tgt == TGT_OPND)   opnd_q <= req.val;
            if (req.tgt == TGT_OPCODE) op_q   <= op_e'(req.val[OP_W-1:0]);
        end
    end

    prot_bank #(
        .ADDR_W(ADDR_W), .BANK_SHIFT(BANK_SHIFT),
        .WIN_BYTES(WIN_BYTES), .ROM_BYTES(ROM_BYTES)
    ) i_bank (
        .clk     (clk),
        .rst     (rst),
        .load    (req.tgt == TGT_BANK),
        .byte_in (req.val),
        .base    (base_q)
    );

    prot_xlate #(.ADDR_W(ADDR_W), .LOW_LSB(REGION_LSB)) i_xlate (
        .rd_addr  (rd_addr),
        .base     (base_q),
        .rom_addr (rom_addr)
    );

    assign prot_hit  = rd_addr[ADDR_W-1:HIT_LSB] == HIT_R;
    assign prot_data = apply_op(op_q, opnd_q);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (opnd_q == '0 && op_q == OP_SHL && base_q == '0));

    assert_opnd_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[ADDR_W-1:REGION_LSB] == 'd6 && !wr_addr[1]) |=> opnd_q == $past(wr_data));

    assert_opcode_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[ADDR_W-1:REGION_LSB] == 'd6 && wr_addr[1])
        |=> (op_q == op_e'($past(wr_data[1:0])) && $stable(opnd_q)));

    assert_bits_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_SWAP || op_q == OP_REV) |-> $countones(prot_data) == $countones(opnd_q));

    assert_low_or_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[ADDR_W-1:REGION_LSB] == '0) |-> ((rom_addr & rd_addr) == rd_addr));

    assert_high_pass_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[ADDR_W-1:REGION_LSB] != '0) |-> (rom_addr == rd_addr));

    assert_ignore_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[ADDR_W-1:HIT_LSB] != HIT_R)
        |=> ($stable(opnd_q) && $stable(op_q) && $stable(base_q)));
endmodule

// File: tb/test_prot_or_bank_alu.sv
module test_prot_or_bank_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [23:0] rd_addr = '0;
    logic        prot_hit;
    logic [7:0]  prot_data;
    logic [23:0] rom_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prot_or_bank_alu i_prot_or_bank_alu (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .prot_hit(prot_hit), .prot_data(prot_data), .rom_addr(rom_addr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [23:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic look(logic [23:0] a);
        rd_addr = a;
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        look(24'h012345);
        chk("R1 result", prot_data, 8'h00);
        chk("R1 rom addr", rom_addr, 24'h012345);
        look(24'h000000);
        chk("R1 bank zero", rom_addr, 24'h000000);
    endtask

    task automatic t_ops;
        bus_wr(24'h600000, 8'hA5);
        look(24'h600000);
        chk("R4 shl 0xA5", prot_data, 8'h4A);
        bus_wr(24'h600002, 8'h01);
        chk("R5 shr 0xA5", prot_data, 8'h52);
        bus_wr(24'h600002, 8'h02);
        chk("R6 swap 0xA5", prot_data, 8'h5A);
        bus_wr(24'h600002, 8'hFE);
        chk("R3 opcode bits 1:0 only, operand kept", prot_data, 8'h5A);
        bus_wr(24'h600002, 8'h03);
        bus_wr(24'h600000, 8'h1E);
        chk("R7 reverse 0x1E", prot_data, 8'h78);
        bus_wr(24'h6FFFFD, 8'h01);
        chk("R2 operand load at top of window", prot_data, 8'h80);
    endtask

    task automatic t_hit;
        look(24'h5FFFFF); chk("R8 below", prot_hit, 1'b0);
        look(24'h600000); chk("R8 low edge", prot_hit, 1'b1);
        look(24'h7FFFFF); chk("R8 high edge", prot_hit, 1'b1);
        look(24'h800000); chk("R8 above", prot_hit, 1'b0);
    endtask

    task automatic t_bank;
        bus_wr(24'h700001, 8'h05);
        look(24'h001234); chk("R9 R11 or base 0x28000", rom_addr, 24'h029234);
        look(24'h008000); chk("R11 or not add", rom_addr, 24'h028000);
        look(24'h0FFFFF); chk("R11 last low addr", rom_addr, 24'h0FFFFF);
        look(24'h100000); chk("R11 pass through", rom_addr, 24'h100000);
    endtask

    task automatic t_range;
        bus_wr(24'h7FFFFF, 8'd125);
        look(24'h000000); chk("R10 byte 125 accepted", rom_addr, 24'h3E8000);
        bus_wr(24'h700000, 8'd126);
        look(24'h000000); chk("R10 byte 126 rejected", rom_addr, 24'h3E8000);
        bus_wr(24'h700000, 8'hFF);
        look(24'h000000); chk("R10 byte 255 rejected", rom_addr, 24'h3E8000);
    endtask

    task automatic t_ignore;
        bus_wr(24'h5FFFFC, 8'h33);
        bus_wr(24'h800000, 8'h00);
        bus_wr(24'h000002, 8'h01);
        look(24'h000000);
        chk("R12 bank kept", rom_addr, 24'h3E8000);
        chk("R12 operand and opcode kept", prot_data, 8'h80);
    endtask

    initial begin
        t_reset();
        t_ops();
        t_hit();
        t_bank();
        t_range();
        t_ignore();
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule